// File: doc/BRIEF.md
# Output Voltage Supervisor and Fault Latch

This block watches a sampled output-voltage code and compares it each clock with the reference code programmed for the regulator. From that comparison it drives a power-good flag through a window with hysteresis, detects an undervoltage relative to the reference, and detects an overvoltage against a fixed absolute code. Protective states are latched. An overvoltage starts a crowbar by commanding the low-side switches on. An undervoltage, or the "no processor" identification code (all ones), commands every switch off.

The sequencer enables power-good and undervoltage checking only once soft start is far enough along. The overvoltage check is always armed. All latches clear only through the power-cycle reset, which is asynchronous active low and is released synchronously inside the block. Every ratio is built with shift-and-add scaling on both sides of each comparison, so the thresholds are exact rational fractions of the reference and the block needs no divider.

Top module: `vout_supervisor`

## Requirements
- R1: After the power-cycle reset `rst_n` is released, `pgood`, `fault`, `force_ls_on` and `all_off` are all 0.
- R2: When `pg_enable` is 0 at a clock edge, `pgood` is 0 after that edge.
- R3: With power-good asserted, `pgood` drops at the next edge when 8·vout > 9·ref (above 112.5 %) or 8·vout < 7·ref (below 87.5 %). Inside that outer window it stays high.
- R4: With power-good deasserted and `pg_enable` at 1, `pgood` rises at the next edge only when 15·ref ≤ 16·vout ≤ 17·ref (93.75 % to 106.25 %). Outside that inner band it stays low.
- R5: When `uv_enable` is 1 and 5·vout < 3·ref (below 60 %), `fault` and `all_off` are set at the next edge and latched. When `uv_enable` is 0, the comparison has no effect on `fault`.
- R6: When vout > OV_CODE, `fault` and `force_ls_on` are set at the next edge and latched, whatever the enables, reference and identification code are.
- R7: An identification code of all ones (5'b11111) latches `all_off` at the next edge and leaves `fault` at 0. Other codes have no effect.
- R8: Every latched state persists until `rst_n` is asserted, even after the inputs return to normal. `pgood` stays 0 while any latch is set.
- R9: `force_ls_on` and `all_off` are never both 1. A latched overvoltage takes precedence and clears `all_off`.
- R10: Outputs change only at the clock edge that samples the inputs (one register of latency).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-cycle reset, asynchronous, active low |
| vout_code | input | CODE_W | Sampled output-voltage code |
| vref_code | input | CODE_W | Programmed reference code |
| vid_code | input | VID_W | Voltage identification code |
| pg_enable | input | 1 | Sequencer enable for power-good |
| uv_enable | input | 1 | Sequencer enable for undervoltage detection |
| pgood | output | 1 | Output voltage within window |
| fault | output | 1 | Latched over- or undervoltage |
| force_ls_on | output | 1 | Crowbar: hold low-side switches on |
| all_off | output | 1 | Turn every switch off |

## Verification
The bench builds the block with CODE_W = 6 and OV_CODE = 50. At that size every pairing of output and reference code from 0 to 50 can be swept, so every rounding edge of the 7/8, 9/8, 15/16, 17/16 and 3/5 ratios is checked, including a zero reference. Each pairing is applied from both hysteresis states, and the undervoltage trip is applied from a fresh reset. The overvoltage sweep covers the whole 6-bit range of the output code. The identification sweep covers all 32 codes. Latch persistence, crowbar priority and the one-cycle latency are then exercised in short directed sequences.

// File: rtl/sup_pkg.sv
package sup_pkg;
  // Latched protection state
  typedef struct packed {
    logic ov;     // overvoltage crowbar
    logic uv;     // undervoltage shutdown
    logic nocpu;  // no-processor code seen
  } latch_t;

  localparam int SCALE_EXTRA = 5;  // bits added by the largest constant factor (17)
endpackage

// File: rtl/sup_scale.sv
// Constant multiply built from shifted copies of the input.
module sup_scale #(
  parameter int IN_W = 6,
  parameter int MUL  = 9,
  localparam int MUL_BITS = $clog2(MUL + 1),
  localparam int OUT_W    = IN_W + MUL_BITS
) (
  input  logic [IN_W-1:0]  in_val,
  output logic [OUT_W-1:0] out_val
);
  logic [OUT_W-1:0] part [MUL_BITS+1];

  assign part[0] = '0;
  for (genvar k = 0; k < MUL_BITS; k++) begin : g_term
    if (((MUL >> k) & 1) == 1) begin : g_add
      assign part[k+1] = part[k] + (OUT_W'(in_val) << k);
    end else begin : g_skip
      assign part[k+1] = part[k];
    end
  end
  assign out_val = part[MUL_BITS];
endmodule

// File: rtl/sup_window.sv
// Ratiometric and absolute comparisons of output code vs reference code.
module sup_window #(
  parameter int CODE_W  = 6,
  parameter int OV_CODE = 50,
  localparam int CW = CODE_W + sup_pkg::SCALE_EXTRA
) (
  input  logic [CODE_W-1:0] vout_code,
  input  logic [CODE_W-1:0] vref_code,
  output logic              outer_ok,
  output logic              inner_ok,
  output logic              uv_low,
  output logic              ov_high
);
  logic [CODE_W+3:0] v8;
  logic [CODE_W+4:0] v16;
  logic [CODE_W+2:0] v5;
  logic [CODE_W+3:0] r9;
  logic [CODE_W+2:0] r7;
  logic [CODE_W+4:0] r17;
  logic [CODE_W+3:0] r15;
  logic [CODE_W+1:0] r3;

  sup_scale #(.IN_W(CODE_W), .MUL(8))  u_v8  (.in_val(vout_code), .out_val(v8));
  sup_scale #(.IN_W(CODE_W), .MUL(16)) u_v16 (.in_val(vout_code), .out_val(v16));
  sup_scale #(.IN_W(CODE_W), .MUL(5))  u_v5  (.in_val(vout_code), .out_val(v5));
  sup_scale #(.IN_W(CODE_W), .MUL(9))  u_r9  (.in_val(vref_code), .out_val(r9));
  sup_scale #(.IN_W(CODE_W), .MUL(7))  u_r7  (.in_val(vref_code), .out_val(r7));
  sup_scale #(.IN_W(CODE_W), .MUL(17)) u_r17 (.in_val(vref_code), .out_val(r17));
  sup_scale #(.IN_W(CODE_W), .MUL(15)) u_r15 (.in_val(vref_code), .out_val(r15));
  sup_scale #(.IN_W(CODE_W), .MUL(3))  u_r3  (.in_val(vref_code), .out_val(r3));

  logic [CW-1:0] e_v8, e_v16, e_v5, e_r9, e_r7, e_r17, e_r15, e_r3;

  always_comb begin
    e_v8  = CW'(v8);
    e_v16 = CW'(v16);
    e_v5  = CW'(v5);
    e_r9  = CW'(r9);
    e_r7  = CW'(r7);
    e_r17 = CW'(r17);
    e_r15 = CW'(r15);
    e_r3  = CW'(r3);
    outer_ok = (e_v8 <= e_r9) && (e_v8 >= e_r7);
    inner_ok = (e_v16 <= e_r17) && (e_v16 >= e_r15);
    uv_low   = (e_v5 < e_r3);
    ov_high  = (vout_code > CODE_W'(OV_CODE));
  end
endmodule

// File: rtl/sup_fault_latch.sv
// Protection latches; cleared only by reset.
module sup_fault_latch (
  input  logic                  clk,
  input  logic                  srst_n,
  input  logic                  ov_hit,
  input  logic                  uv_hit,
  input  logic                  nocpu_hit,
  output sup_pkg::latch_t       state_q,
  output sup_pkg::latch_t       state_d
);
  logic upd_en;

  always_comb begin
    state_d       = state_q;
    state_d.ov    = state_q.ov    | ov_hit;
    state_d.uv    = state_q.uv    | uv_hit;
    state_d.nocpu = state_q.nocpu | nocpu_hit;
    upd_en        = ov_hit | uv_hit | nocpu_hit;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q <= '0;
    end else if (upd_en) begin
      state_q <= state_d;
    end
  end
endmodule

// File: rtl/sup_pg_hyst.sv
// Power-good state with optional hysteresis band.
module sup_pg_hyst #(
  parameter bit HYST = 1'b1
) (
  input  logic clk,
  input  logic srst_n,
  input  logic en,
  input  logic block,
  input  logic outer_ok,
  input  logic inner_ok,
  output logic pg_q
);
  logic set_ok;
  logic pg_d;

  if (HYST) begin : g_hyst
    assign set_ok = inner_ok;
  end else begin : g_plain
    assign set_ok = outer_ok;
  end

  always_comb begin
    pg_d = en && !block && (set_ok || (pg_q && outer_ok));
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      pg_q <= 1'b0;
    end else begin
      pg_q <= pg_d;
    end
  end
endmodule

// File: rtl/vout_supervisor.sv
module vout_supervisor #(
  parameter int CODE_W  = 10,
  parameter int VID_W   = 5,
  parameter int OV_CODE = 900,
  parameter bit PG_HYST = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] vout_code,
  input  logic [CODE_W-1:0] vref_code,
  input  logic [VID_W-1:0]  vid_code,
  input  logic              pg_enable,
  input  logic              uv_enable,
  output logic              pgood,
  output logic              fault,
  output logic              force_ls_on,
  output logic              all_off
);
  import sup_pkg::*;

  // Asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  logic outer_ok, inner_ok, uv_low, ov_high;

  sup_window #(.CODE_W(CODE_W), .OV_CODE(OV_CODE)) u_win (
    .vout_code (vout_code),
    .vref_code (vref_code),
    .outer_ok  (outer_ok),
    .inner_ok  (inner_ok),
    .uv_low    (uv_low),
    .ov_high   (ov_high)
  );

  logic   uv_hit, nocpu_hit;
  latch_t lat_q, lat_d;

  always_comb begin
    uv_hit    = uv_enable && uv_low;
    nocpu_hit = &vid_code;
  end

  sup_fault_latch u_lat (
    .clk       (clk),
    .srst_n    (rst_sync_n),
    .ov_hit    (ov_high),
    .uv_hit    (uv_hit),
    .nocpu_hit (nocpu_hit),
    .state_q   (lat_q),
    .state_d   (lat_d)
  );

  logic pg_block;
  logic pg_q;

  assign pg_block = |lat_d;

  sup_pg_hyst #(.HYST(PG_HYST)) u_pg (
    .clk      (clk),
    .srst_n   (rst_sync_n),
    .en       (pg_enable),
    .block    (pg_block),
    .outer_ok (outer_ok),
    .inner_ok (inner_ok),
    .pg_q     (pg_q)
  );

  always_comb begin
    pgood       = pg_q;
    fault       = lat_q.ov | lat_q.uv;
    force_ls_on = lat_q.ov;
    all_off     = !lat_q.ov && (lat_q.uv || lat_q.nocpu);
  end
endmodule

// File: rtl/sup_checker.sv
module sup_checker #(
  parameter int CODE_W  = 10,
  parameter int VID_W   = 5,
  parameter int OV_CODE = 900
) (
  input logic              clk,
  input logic              srst_n,
  input logic [CODE_W-1:0] vout_code,
  input logic [CODE_W-1:0] vref_code,
  input logic [VID_W-1:0]  vid_code,
  input logic              pg_enable,
  input logic              uv_enable,
  input logic              pgood,
  input logic              fault,
  input logic              force_ls_on,
  input logic              all_off
);
  localparam int W = CODE_W + 6;
  logic [W-1:0] v_w, r_w;
  assign v_w = W'(vout_code);
  assign r_w = W'(vref_code);

  AST_PG_NEEDS_EN: assert property (@(posedge clk) disable iff (!srst_n)
    !pg_enable |=> !pgood); // R2

  AST_PG_IN_WINDOW: assert property (@(posedge clk) disable iff (!srst_n)
    (pgood && !$past(pgood)) |-> $past((v_w * 16 <= r_w * 17) && (v_w * 16 >= r_w * 15))); // R4

  AST_PG_DROPS: assert property (@(posedge clk) disable iff (!srst_n)
    ((v_w * 8 > r_w * 9) || (v_w * 8 < r_w * 7)) |=> !pgood); // R3

  AST_UV_TRIP: assert property (@(posedge clk) disable iff (!srst_n)
    (uv_enable && (v_w * 5 < r_w * 3)) |=> fault); // R5

  AST_OV_CROWBAR: assert property (@(posedge clk) disable iff (!srst_n)
    (vout_code > CODE_W'(OV_CODE)) |=> (fault && force_ls_on)); // R6

  AST_NOCPU_OFF: assert property (@(posedge clk) disable iff (!srst_n)
    (&vid_code) |=> (all_off || force_ls_on)); // R7

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!srst_n)
    fault |=> fault); // R8

  AST_OFF_STICKY: assert property (@(posedge clk) disable iff (!srst_n)
    (all_off || force_ls_on) |=> (all_off || force_ls_on)); // R8

  AST_PG_BLOCKED: assert property (@(posedge clk) disable iff (!srst_n)
    pgood |-> (!fault && !all_off)); // R8

  AST_NO_BOTH_CMDS: assert property (@(posedge clk) disable iff (!srst_n)
    !(force_ls_on && all_off)); // R9
endmodule

bind vout_supervisor sup_checker #(
  .CODE_W(CODE_W), .VID_W(VID_W), .OV_CODE(OV_CODE)
) u_chk (
  .clk         (clk),
  .srst_n      (rst_sync_n),
  .vout_code   (vout_code),
  .vref_code   (vref_code),
  .vid_code    (vid_code),
  .pg_enable   (pg_enable),
  .uv_enable   (uv_enable),
  .pgood       (pgood),
  .fault       (fault),
  .force_ls_on (force_ls_on),
  .all_off     (all_off)
);

// File: tb/sim_vout_supervisor.sv
`timescale 1ns/1ps
module sim_vout_supervisor;
  localparam int CODE_W  = 6;
  localparam int VID_W   = 5;
  localparam int OV_CODE = 50;

  logic              clk;
  logic              rst_n;
  logic [CODE_W-1:0] vout_code;
  logic [CODE_W-1:0] vref_code;
  logic [VID_W-1:0]  vid_code;
  logic              pg_enable;
  logic              uv_enable;
  logic              pgood, fault, force_ls_on, all_off;

  int checks;
  int failures;
  bit done;

  vout_supervisor #(.CODE_W(CODE_W), .VID_W(VID_W), .OV_CODE(OV_CODE), .PG_HYST(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .vout_code(vout_code), .vref_code(vref_code),
    .vid_code(vid_code), .pg_enable(pg_enable), .uv_enable(uv_enable),
    .pgood(pgood), .fault(fault), .force_ls_on(force_ls_on), .all_off(all_off)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic bit outer_f(int v, int r);
    return (8 * v <= 9 * r) && (8 * v >= 7 * r);
  endfunction
  function automatic bit inner_f(int v, int r);
    return (16 * v <= 17 * r) && (16 * v >= 15 * r);
  endfunction
  function automatic bit uv_f(int v, int r);
    return 5 * v < 3 * r;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // Drive at a falling edge, advance to the next falling edge.
  task automatic step(input int v, input int r, input int vid, input bit pge, input bit uve);
    vout_code = CODE_W'(v);
    vref_code = CODE_W'(r);
    vid_code  = VID_W'(vid);
    pg_enable = pge;
    uv_enable = uve;
    @(negedge clk);
  endtask

  task automatic do_reset();
    vout_code = '0; vref_code = '0; vid_code = '0;
    pg_enable = 1'b0; uv_enable = 1'b0;
    rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    checks = 0; failures = 0; done = 1'b0;
    @(negedge clk);
    do_reset();
    // R1: reset state
    chk("R1 pgood", pgood, 0);
    chk("R1 fault", fault, 0);
    chk("R1 force_ls_on", force_ls_on, 0);
    chk("R1 all_off", all_off, 0);

    // R10: latency of one edge
    vout_code = 6'd32; vref_code = 6'd32; pg_enable = 1'b1;
    #1 chk("R10 before edge", pgood, 0);
    @(negedge clk);
    chk("R10 after edge", pgood, 1);

    // R2/R3/R4 sweep, uv disabled so R5 also checked as ignored
    for (int r = 0; r <= OV_CODE; r++) begin
      for (int v = 0; v <= OV_CODE; v++) begin
        step(r, r, 0, 1'b1, 1'b0);
        chk("R4 set at ref", pgood, 1);
        step(v, r, 0, 1'b1, 1'b0);
        chk("R3 outer window", pgood, outer_f(v, r));
        chk("R5 uv ignored when disabled", fault, 0);
        step(v, r, 0, 1'b0, 1'b0);
        chk("R2 pgood low when disabled", pgood, 0);
        step(v, r, 0, 1'b1, 1'b0);
        chk("R4 inner band", pgood, inner_f(v, r));
      end
    end

    // R5 undervoltage trip and R8 persistence
    do_reset();
    for (int r = 0; r <= OV_CODE; r++) begin
      for (int v = 0; v <= OV_CODE; v++) begin
        step(v, r, 0, 1'b0, 1'b1);
        chk("R5 uv fault", fault, uv_f(v, r));
        if (uv_f(v, r)) begin
          chk("R5 uv all_off", all_off, 1);
          chk("R9 uv no crowbar", force_ls_on, 0);
          step(r, r, 0, 1'b1, 1'b1);
          step(r, r, 0, 1'b1, 1'b1);
          chk("R8 uv held", fault, 1);
          chk("R8 pgood blocked", pgood, 0);
          do_reset();
        end
      end
    end

    // R6 overvoltage over the full code range
    for (int v = 0; v < (1 << CODE_W); v++) begin
      step(v, 32, 0, 1'b1, 1'b0);
      chk("R6 ov fault", fault, (v > OV_CODE) ? 1 : 0);
      chk("R6 ov crowbar", force_ls_on, (v > OV_CODE) ? 1 : 0);
      chk("R9 ov all_off low", all_off, 0);
      if (v > OV_CODE) begin
        chk("R8 pgood low on ov", pgood, 0);
        repeat (4) step(32, 32, 0, 1'b1, 1'b0);
        chk("R8 ov held", force_ls_on, 1);
        chk("R8 ov pgood blocked", pgood, 0);
        do_reset();
      end
    end

    // R7 identification code sweep
    for (int id = 0; id < (1 << VID_W); id++) begin
      step(32, 32, id, 1'b1, 1'b0);
      chk("R7 nocpu all_off", all_off, (id == 31) ? 1 : 0);
      chk("R7 nocpu no fault", fault, 0);
    end
    repeat (4) step(32, 32, 3, 1'b1, 1'b0);
    chk("R8 nocpu held", all_off, 1);
    chk("R8 nocpu pgood blocked", pgood, 0);

    // R9 overvoltage overrides nocpu
    step(60, 32, 3, 1'b1, 1'b0);
    chk("R9 ov over nocpu crowbar", force_ls_on, 1);
    chk("R9 ov over nocpu all_off", all_off, 0);
    do_reset();

    // R9 overvoltage overrides undervoltage
    step(0, 40, 0, 1'b0, 1'b1);
    chk("R9 uv first all_off", all_off, 1);
    step(60, 40, 0, 1'b0, 1'b1);
    chk("R9 ov after uv crowbar", force_ls_on, 1);
    chk("R9 ov after uv all_off", all_off, 0);
    chk("R9 fault", fault, 1);

    // R1 again: reset clears all latches
    do_reset();
    chk("R1 cleared fault", fault, 0);
    chk("R1 cleared crowbar", force_ls_on, 0);
    chk("R1 cleared all_off", all_off, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule